// File: doc/BRIEF.md
# Splittable 64-bit Hash Processing Element

This block is one datapath slice for the compression rounds of hash algorithms. It is built from two 32-bit halves that can run in two ways. With `dword` low, the halves are two independent 32-bit lanes, so two messages of a 32-bit-word algorithm (MD5, SHA-1, SHA-224/256, SM3) advance together. With `dword` high, the halves join into one 64-bit lane for SHA-384/512. A fixed 64-bit datapath would leave half its width idle on the 32-bit algorithms; this slice avoids that.

Each input word holds both lanes: bits 63:32 form the high lane and bits 31:0 the low lane. The slice has three functions, chosen by `unit_sel`. The first is a bitwise three-input logic unit, built as a cascade of configurable cells. The second is an adder whose halves are linked by a carry only in joined mode. The third is a shift/XOR unit, which can make one shift or rotate, or XOR together three right-rotations of the same word. Both lanes share the function select and the shift amounts. The result is registered and appears one clock after a valid input. Round sequencing, constants and message scheduling are handled outside this block.

Top module: `hpe_slice`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next cycle shows `out_valid` = 0 and `result` = 0. This holds even if `in_valid` is high.
- R2: A valid input (`in_valid` = 1) at an edge gives `out_valid` = 1 and its result in the following cycle. An edge with `in_valid` = 0 gives `out_valid` = 0 and leaves `result` unchanged, whatever the other inputs are.
- R3: With `unit_sel` = 1 (add) and `dword` = 0, `result[31:0]` = (opa[31:0] + opb[31:0]) mod 2^32 and `result[63:32]` = (opa[63:32] + opb[63:32]) mod 2^32. No carry passes from the low lane to the high lane.
- R4: With `unit_sel` = 1 and `dword` = 1, `result` = (opa + opb) mod 2^64. The low lane's carry enters the high lane.
- R5: With `unit_sel` = 0 (logic), every bit of `result` is a function of opa, opb and opc, applied bit by bit in either mode. The codes are: `op_sel` 0 gives (a&b)|(~a&c); 1 gives majority(a,b,c); 2 gives a^b^c; 3 gives (a&c)|(b&~c); 4 gives b^(a|~c); codes 5 to 7 give 0.
- R6: With `unit_sel` = 2 (shift) and `dword` = 0, each 32-bit lane of `opa` is processed on its own, using only `amt0[4:0]` (bit 5 is ignored). The codes are: `op_sel[1:0]` 0 is rotate right, 1 is rotate left, 2 is logical shift right.
- R7: With `unit_sel` = 2 and `dword` = 1, the same three single-shift codes act on the whole 64-bit `opa` with the 6-bit `amt0`.
- R8: With `unit_sel` = 2 and `op_sel[1:0]` = 3, the result is rotr(opa,amt0) ^ rotr(opa,amt1) ^ rotr(opa,amt2). In split mode this is per 32-bit lane with 5-bit amounts; in joined mode it is on 64 bits with 6-bit amounts.
- R9: With `unit_sel` = 3, a valid input gives `result` = 0.
- R10: `dword` is taken with each valid input. Back-to-back inputs that alternate the mode each get the result of their own mode, with no dead cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| dword | input | 1 | 1 = one joined 64-bit lane, 0 = two 32-bit lanes |
| unit_sel | input | 2 | 0 logic, 1 add, 2 shift/XOR, 3 none |
| op_sel | input | 3 | Logic function code, or shift code in bits 1:0 |
| amt0 | input | 6 | First shift/rotate amount |
| amt1 | input | 6 | Second rotate amount (three-rotation XOR only) |
| amt2 | input | 6 | Third rotate amount (three-rotation XOR only) |
| opa | input | 64 | Operand a (shift source) |
| opb | input | 64 | Operand b |
| opc | input | 64 | Operand c (logic unit only) |
| out_valid | output | 1 | Registered result is valid |
| result | output | 64 | Registered result word |

## Verification
The adder is tried with operands whose low lanes overflow, once in each mode. These patterns show whether the carry link is cut in split mode and connected in joined mode. A high-lane overflow and an all-ones plus one wrap show that carries out of the top are dropped. Rotations use a word whose halves differ and an amount with bit 5 set. This separates two 32-bit rotations from one 64-bit rotation and shows whether the spare amount bit leaks into split mode. The logic codes run on three orthogonal stripe patterns, so every row of each truth table is hit. The SHA-256 and SHA-512 sigma amounts, the idle cycles with changing inputs, and back-to-back inputs that alternate the mode check the XOR path, the hold behaviour and the per-input mode.

// File: rtl/hpe_pkg.sv
// hpe_pkg: shared widths, selector encodings and logic-cell truth tables
// for the splittable hash processing element.
// Assumes: a truth table is indexed by {a, b, c} of one bit column.
package hpe_pkg;

    localparam int LANE_W = 32;

    typedef enum logic [1:0] {
        UNIT_LOGIC = 2'd0,
        UNIT_ADD   = 2'd1,
        UNIT_SHIFT = 2'd2,
        UNIT_NONE  = 2'd3
    } unit_e;

    typedef enum logic [2:0] {
        LOP_CHOOSE = 3'd0,
        LOP_MAJ    = 3'd1,
        LOP_PAR    = 3'd2,
        LOP_ZSEL   = 3'd3,
        LOP_IMIX   = 3'd4
    } lop_e;

    typedef enum logic [1:0] {
        SH_ROTR = 2'd0,
        SH_ROTL = 2'd1,
        SH_SHR  = 2'd2,
        SH_SIG3 = 2'd3
    } shop_e;

    // Pass-through table: the cell output equals its first input.
    localparam logic [7:0] TT_PASS_A = 8'hF0;

    // Truth table for the first cell layer, selected by the logic code.
    function automatic logic [7:0] lop_table(input logic [2:0] code);
        logic [7:0] tt;
        case (code)
            LOP_CHOOSE: tt = 8'hCA;
            LOP_MAJ:    tt = 8'hE8;
            LOP_PAR:    tt = 8'h96;
            LOP_ZSEL:   tt = 8'hE4;
            LOP_IMIX:   tt = 8'h39;
            default:    tt = 8'h00;
        endcase
        return tt;
    endfunction

endpackage

// File: rtl/hpe_logic_lane.sv
// hpe_logic_lane: bitwise three-input logic for one lane, built as a cascade
// of NLAYER layers of 3-input configurable cells. The first layer takes
// (x, y, z); each later layer takes (previous layer, y, z).
// Assumes: the function code is decoded into the first layer; later layers
// are set to pass their first input, so deeper codes can be added later.
module hpe_logic_lane
    import hpe_pkg::*;
#(
    parameter int W      = 32,
    parameter int NLAYER = 3
) (
    input  logic [2:0]   op,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] f
);

    logic [NLAYER-1:0][7:0]  tt;
    logic [NLAYER:0][W-1:0]  stage;

    // Configure every layer from the function code.
    always_comb begin
        for (int l = 0; l < NLAYER; l++) begin
            tt[l] = (l == 0) ? lop_table(op) : TT_PASS_A;
        end
    end

    assign stage[0] = x;

    genvar l, b;
    generate
        for (l = 0; l < NLAYER; l++) begin : g_layer
            for (b = 0; b < W; b++) begin : g_cell
                assign stage[l+1][b] = tt[l][{stage[l][b], y[b], z[b]}];
            end
        end
    endgenerate

    assign f = stage[NLAYER];

endmodule

// File: rtl/hpe_split_adder.sv
// hpe_split_adder: two W-bit adders. When joined, the low carry-out feeds
// the high carry-in (a 2W-bit ripple adder); otherwise they are independent.
// Assumes: carries out of the top of either lane are dropped.
module hpe_split_adder #(
    parameter int W = 32
) (
    input  logic           joined,
    input  logic [2*W-1:0] a,
    input  logic [2*W-1:0] b,
    output logic [2*W-1:0] sum
);

    logic [W:0]   lo_sum;
    logic         link_c;
    logic [W-1:0] hi_sum;

    // Low lane sum with its carry out.
    always_comb lo_sum = {1'b0, a[W-1:0]} + {1'b0, b[W-1:0]};

    // The carry link exists only in joined mode.
    always_comb link_c = joined & lo_sum[W];

    // High lane sum with the optional carry in.
    always_comb hi_sum = a[2*W-1:W] + b[2*W-1:W] + {{(W-1){1'b0}}, link_c};

    assign sum = {hi_sum, lo_sum[W-1:0]};

endmodule

// File: rtl/hpe_shift_lane.sv
// hpe_shift_lane: shift/XOR unit for a W-bit word. Three shifters and two
// XOR stages; gives one shift (rotr, rotl, shr by n0), or the XOR of three
// right-rotations by n0, n1 and n2.
// Assumes: W is a power of two; amounts are taken modulo W by their width.
module hpe_shift_lane
    import hpe_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [1:0]         kind,
    input  logic [$clog2(W)-1:0] n0,
    input  logic [$clog2(W)-1:0] n1,
    input  logic [$clog2(W)-1:0] n2,
    input  logic [W-1:0]       x,
    output logic [W-1:0]       y
);

    localparam int AW = $clog2(W);

    function automatic logic [W-1:0] rot_r(input logic [W-1:0] v, input logic [AW-1:0] n);
        return (v >> n) | (v << (W - int'(n)));
    endfunction

    function automatic logic [W-1:0] rot_l(input logic [W-1:0] v, input logic [AW-1:0] n);
        return (v << n) | (v >> (W - int'(n)));
    endfunction

    logic [W-1:0] sh0, sh1, sh2;

    // First shifter: the kind of shift is chosen by the code.
    always_comb begin
        case (kind)
            SH_ROTL: sh0 = rot_l(x, n0);
            SH_SHR:  sh0 = x >> n0;
            default: sh0 = rot_r(x, n0);
        endcase
    end

    // Second and third shifters: right-rotations used by the XOR form.
    always_comb sh1 = rot_r(x, n1);
    always_comb sh2 = rot_r(x, n2);

    // Two XOR stages, or the single shift alone.
    always_comb y = (kind == SH_SIG3) ? (sh0 ^ sh1 ^ sh2) : sh0;

endmodule

// File: rtl/hpe_slice.sv
// hpe_slice: top of the splittable hash processing element. Two 32-bit lanes
// serve two independent operations (dword = 0) or one 64-bit operation
// (dword = 1). The function is picked by unit_sel; the result is registered.
// Assumes: both lanes share the controls and amounts; the mode is taken
// with each valid input; synchronous active-low reset.
module hpe_slice
    import hpe_pkg::*;
#(
    parameter int LW = LANE_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic                         dword,
    input  logic [1:0]                   unit_sel,
    input  logic [2:0]                   op_sel,
    input  logic [$clog2(2*LW)-1:0]      amt0,
    input  logic [$clog2(2*LW)-1:0]      amt1,
    input  logic [$clog2(2*LW)-1:0]      amt2,
    input  logic [2*LW-1:0]              opa,
    input  logic [2*LW-1:0]              opb,
    input  logic [2*LW-1:0]              opc,
    output logic                         out_valid,
    output logic [2*LW-1:0]              result
);

    localparam int DW    = 2 * LW;
    localparam int LAW   = $clog2(LW);
    localparam int NLANE = 2;

    logic [DW-1:0] logic_res;
    logic [DW-1:0] add_res;
    logic [DW-1:0] shift_split;
    logic [DW-1:0] shift_join;
    logic [DW-1:0] next_res;

    // Per-lane logic units and split shifters.
    genvar h;
    generate
        for (h = 0; h < NLANE; h++) begin : g_lane
            hpe_logic_lane #(.W(LW), .NLAYER(3)) u_logic (
                .op (op_sel),
                .x  (opa[h*LW +: LW]),
                .y  (opb[h*LW +: LW]),
                .z  (opc[h*LW +: LW]),
                .f  (logic_res[h*LW +: LW])
            );
            hpe_shift_lane #(.W(LW)) u_shift (
                .kind (op_sel[1:0]),
                .n0   (amt0[LAW-1:0]),
                .n1   (amt1[LAW-1:0]),
                .n2   (amt2[LAW-1:0]),
                .x    (opa[h*LW +: LW]),
                .y    (shift_split[h*LW +: LW])
            );
        end
    endgenerate

    // Dedicated full-width shifter for joined mode.
    hpe_shift_lane #(.W(DW)) u_shift_join (
        .kind (op_sel[1:0]),
        .n0   (amt0),
        .n1   (amt1),
        .n2   (amt2),
        .x    (opa),
        .y    (shift_join)
    );

    // Adder with the mode-controlled carry link.
    hpe_split_adder #(.W(LW)) u_add (
        .joined (dword),
        .a      (opa),
        .b      (opb),
        .sum    (add_res)
    );

    // Pick the selected unit's output.
    always_comb begin
        case (unit_sel)
            UNIT_LOGIC: next_res = logic_res;
            UNIT_ADD:   next_res = add_res;
            UNIT_SHIFT: next_res = dword ? shift_join : shift_split;
            default:    next_res = '0;
        endcase
    end

    // Register the result and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= next_res;
            end
        end
    end

    // R1: reset clears the outputs.
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0));

    // R2: valid input gives a valid output one cycle later.
    p_valid_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: idle edge gives no valid output and holds the result.
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));

    // R3: no carry into the high lane in split mode.
    p_split_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && unit_sel == UNIT_ADD && !dword)
        |=> result[DW-1:LW] == $past(opa[DW-1:LW] + opb[DW-1:LW]));

    // R4: full-width sum in joined mode.
    p_join_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && unit_sel == UNIT_ADD && dword)
        |=> result == $past(opa + opb));

    // R5: parity code is a plain three-way XOR in either mode.
    p_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && unit_sel == UNIT_LOGIC && op_sel == LOP_PAR)
        |=> result == $past(opa ^ opb ^ opc));

    // R9: the unused unit code gives zero.
    p_none_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && unit_sel == UNIT_NONE) |=> result == '0);

endmodule

// File: tb/hpe_slice_tb.sv
// hpe_slice_tb: directed bench for hpe_slice, one task per scenario.
// Inputs change on falling edges; outputs are checked on the next falling edge.
module hpe_slice_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        dword = 1'b0;
    logic [1:0]  unit_sel = 2'd0;
    logic [2:0]  op_sel = 3'd0;
    logic [5:0]  amt0 = '0, amt1 = '0, amt2 = '0;
    logic [63:0] opa = '0, opb = '0, opc = '0;
    logic        out_valid;
    logic [63:0] result;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    hpe_slice u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dword(dword),
        .unit_sel(unit_sel), .op_sel(op_sel), .amt0(amt0), .amt1(amt1),
        .amt2(amt2), .opa(opa), .opb(opb), .opc(opc),
        .out_valid(out_valid), .result(result)
    );

    // ---------------- reference models ----------------
    function automatic logic [31:0] m_rotr32(input logic [31:0] v, input int n);
        logic [63:0] t;
        t = {v, v} >> (n % 32);
        return t[31:0];
    endfunction

    function automatic logic [63:0] m_rotr64(input logic [63:0] v, input int n);
        logic [127:0] t;
        t = {v, v} >> (n % 64);
        return t[63:0];
    endfunction

    function automatic logic [31:0] m_lane_logic(input int code,
        input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
        case (code)
            0: return (a & b) | (~a & c);
            1: return (a & b) | (a & c) | (b & c);
            2: return a ^ b ^ c;
            3: return (a & c) | (b & ~c);
            4: return b ^ (a | ~c);
            default: return 32'h0;
        endcase
    endfunction

    // ---------------- helpers ----------------
    task automatic check(input string what, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    // Apply one valid input at a falling edge and check its result one cycle on.
    task automatic step(input string what, input logic dw, input logic [1:0] us,
        input logic [2:0] op, input logic [5:0] n0, input logic [5:0] n1,
        input logic [5:0] n2, input logic [63:0] a, input logic [63:0] b,
        input logic [63:0] c, input logic [63:0] exp);
        in_valid = 1'b1; dword = dw; unit_sel = us; op_sel = op;
        amt0 = n0; amt1 = n1; amt2 = n2; opa = a; opb = b; opc = c;
        @(negedge clk);
        check({what, " valid (R2)"}, {63'd0, out_valid}, 64'd1);
        check(what, result, exp);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check("R1 out_valid after reset", {63'd0, out_valid}, 64'd0);
        check("R1 result after reset", result, 64'd0);
    endtask

    task automatic t_split_add();
        step("R3 low overflow stays in low lane", 1'b0, 2'd1, 3'd0, 6'd0, 6'd0, 6'd0,
             64'h00000001_FFFFFFFF, 64'h00000002_00000001, 64'd0, 64'h00000003_00000000);
        step("R3 high overflow dropped", 1'b0, 2'd1, 3'd0, 6'd0, 6'd0, 6'd0,
             64'hFFFFFFFF_00000005, 64'h00000001_00000006, 64'd0, 64'h00000000_0000000B);
    endtask

    task automatic t_join_add();
        step("R4 low carry enters high lane", 1'b1, 2'd1, 3'd0, 6'd0, 6'd0, 6'd0,
             64'h00000001_FFFFFFFF, 64'h00000002_00000001, 64'd0, 64'h00000004_00000000);
        step("R4 full wrap", 1'b1, 2'd1, 3'd0, 6'd0, 6'd0, 6'd0,
             64'hFFFFFFFF_FFFFFFFF, 64'h1, 64'd0, 64'h0);
    endtask

    task automatic t_logic();
        logic [63:0] a, b, c, e;
        a = 64'hF0F0F0F0_FF00FF00;
        b = 64'hCCCCCCCC_F0F0F0F0;
        c = 64'hAAAAAAAA_CCCCCCCC;
        for (int code = 0; code < 8; code++) begin
            e = {m_lane_logic(code, a[63:32], b[63:32], c[63:32]),
                 m_lane_logic(code, a[31:0], b[31:0], c[31:0])};
            step($sformatf("R5 logic code %0d", code), code[0], 2'd0, code[2:0],
                 6'd0, 6'd0, 6'd0, a, b, c, e);
        end
    endtask

    task automatic t_shift_split();
        logic [63:0] x;
        x = 64'h80000001_12345678;
        step("R6 rotr 32 amount bit5 ignored", 1'b0, 2'd2, 3'd0, 6'h24, 6'd0, 6'd0, x, 64'd0, 64'd0,
             {m_rotr32(x[63:32], 4), m_rotr32(x[31:0], 4)});
        step("R6 rotl 32 by 31", 1'b0, 2'd2, 3'd1, 6'd31, 6'd0, 6'd0, x, 64'd0, 64'd0,
             {m_rotr32(x[63:32], 1), m_rotr32(x[31:0], 1)});
        step("R6 shr 32 by 31", 1'b0, 2'd2, 3'd2, 6'd31, 6'd0, 6'd0, x, 64'd0, 64'd0,
             {x[63:32] >> 31, x[31:0] >> 31});
    endtask

    task automatic t_shift_join();
        logic [63:0] x;
        x = 64'h80000001_12345678;
        step("R7 rotr 64 by 36", 1'b1, 2'd2, 3'd0, 6'd36, 6'd0, 6'd0, x, 64'd0, 64'd0,
             m_rotr64(x, 36));
        step("R7 rotl 64 by 1", 1'b1, 2'd2, 3'd1, 6'd1, 6'd0, 6'd0, x, 64'd0, 64'd0,
             m_rotr64(x, 63));
        step("R7 shr 64 by 63", 1'b1, 2'd2, 3'd2, 6'd63, 6'd0, 6'd0, x, 64'd0, 64'd0,
             64'd1);
    endtask

    task automatic t_sigma();
        logic [63:0] x;
        x = 64'h6A09E667_BB67AE85;
        step("R8 32-bit sigma0 (2,13,22)", 1'b0, 2'd2, 3'd3, 6'd2, 6'd13, 6'd22, x, 64'd0, 64'd0,
             {m_rotr32(x[63:32], 2) ^ m_rotr32(x[63:32], 13) ^ m_rotr32(x[63:32], 22),
              m_rotr32(x[31:0], 2) ^ m_rotr32(x[31:0], 13) ^ m_rotr32(x[31:0], 22)});
        step("R8 32-bit sigma1 (6,11,25)", 1'b0, 2'd2, 3'd3, 6'd6, 6'd11, 6'd25, x, 64'd0, 64'd0,
             {m_rotr32(x[63:32], 6) ^ m_rotr32(x[63:32], 11) ^ m_rotr32(x[63:32], 25),
              m_rotr32(x[31:0], 6) ^ m_rotr32(x[31:0], 11) ^ m_rotr32(x[31:0], 25)});
        step("R8 64-bit sigma0 (28,34,39)", 1'b1, 2'd2, 3'd3, 6'd28, 6'd34, 6'd39, x, 64'd0, 64'd0,
             m_rotr64(x, 28) ^ m_rotr64(x, 34) ^ m_rotr64(x, 39));
        step("R8 64-bit sigma1 (14,18,41)", 1'b1, 2'd2, 3'd3, 6'd14, 6'd18, 6'd41, x, 64'd0, 64'd0,
             m_rotr64(x, 14) ^ m_rotr64(x, 18) ^ m_rotr64(x, 41));
    endtask

    task automatic t_none();
        step("R9 unused unit gives zero", 1'b1, 2'd3, 3'd2, 6'd5, 6'd0, 6'd0,
             64'hDEADBEEF_01234567, 64'h1, 64'h2, 64'd0);
    endtask

    task automatic t_idle();
        logic [63:0] held;
        step("R2 setup add", 1'b1, 2'd1, 3'd0, 6'd0, 6'd0, 6'd0,
             64'h10, 64'h20, 64'd0, 64'h30);
        held = 64'h30;
        in_valid = 1'b0; opa = 64'hFFFF; opb = 64'h1234; unit_sel = 2'd0;
        @(negedge clk);
        check("R2 no valid on idle cycle", {63'd0, out_valid}, 64'd0);
        check("R2 result held on idle cycle", result, held);
        opa = 64'h5555;
        @(negedge clk);
        check("R2 result still held", result, held);
    endtask

    task automatic t_alternate();
        logic [63:0] a, b;
        a = 64'h7FFFFFFF_FFFFFFFF;
        b = 64'h00000000_00000001;
        step("R10 split then", 1'b0, 2'd1, 3'd0, 6'd0, 6'd0, 6'd0, a, b, 64'd0, 64'h7FFFFFFF_00000000);
        step("R10 joined next", 1'b1, 2'd1, 3'd0, 6'd0, 6'd0, 6'd0, a, b, 64'd0, 64'h80000000_00000000);
        step("R10 split again", 1'b0, 2'd1, 3'd0, 6'd0, 6'd0, 6'd0, a, b, 64'd0, 64'h7FFFFFFF_00000000);
    endtask

    task automatic t_mid_reset();
        in_valid = 1'b1; unit_sel = 2'd1; opa = 64'h5; opb = 64'h6;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset with valid input: out_valid", {63'd0, out_valid}, 64'd0);
        check("R1 reset with valid input: result", result, 64'd0);
        rst_n = 1'b1; in_valid = 1'b0;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_split_add();
        t_join_add();
        t_logic();
        t_shift_split();
        t_shift_join();
        t_sigma();
        t_none();
        t_idle();
        t_alternate();
        t_mid_reset();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule